// File: doc/BRIEF.md
# Two-Level Hardware Event Dispatcher

This block lets a small core run event handlers with no operating system. Event sources post 4-bit event numbers on one of two request ports, urgent or normal, and each port feeds its own FIFO. The dispatcher picks the next event in hardware. It converts the event number into a handler start address through a programmable table and offers that address to the core on a valid/ready handshake.

An urgent event that arrives while a normal handler is running suspends that handler. The block saves the core's current program address in a single context register and dispatches the urgent handler at once. When the urgent work is done, the saved context is dispatched again as a resume, and only then does queued normal work continue. When nothing is queued, running or suspended, a sleep output tells the rest of the system to power down. Any new post clears it in the same cycle.

Top module: `evt_dispatch`

## Requirements
- R1: Each port has its own 8-entry FIFO of 4-bit event numbers. Events of one priority are dispatched in the order they were posted.
- R2: A table of 16 entries of 16 bits is written with `tbl_we`, `tbl_idx` and `tbl_data`. The dispatched address is the entry selected by the event number. An entry never written since reset reads as 0.
- R3: A post to a full FIFO is dropped, and that port's overflow flag (`hi_ovf` or `lo_ovf`) goes to 1. The flag stays at 1 until reset.
- R4: While `disp_valid` is 1 and `disp_ready` is 0, `disp_valid`, `disp_addr`, `disp_hi`, `disp_resume` and `disp_preempt` hold their values. A handler counts as running from the cycle its dispatch is accepted until `done` is pulsed.
- R5: Posts on both ports in the same cycle are both queued. When no handler runs, a queued urgent event is dispatched before a resume or any normal event.
- R6: Preemption happens when a normal handler is running, an urgent event is queued and `done` is low. The urgent event is then dispatched with `disp_hi`=1 and `disp_preempt`=1, and `core_pc` from that cycle is saved.
- R7: While an urgent handler runs, nothing is dispatched until `done` is pulsed. Only one level of nesting exists.
- R8: When no handler runs and no urgent event is queued, a saved context is dispatched as its saved address with `disp_resume`=1 and `disp_hi`=0. This happens before any queued normal event.
- R9: `sleep` goes to 1 one cycle after both FIFOs are empty, no dispatch is pending, no handler runs and no context is saved. It is 0 in any cycle where `hi_post` or `lo_post` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_post | input | 1 | Urgent event post strobe |
| hi_id | input | 4 | Urgent event number |
| lo_post | input | 1 | Normal event post strobe |
| lo_id | input | 4 | Normal event number |
| tbl_we | input | 1 | Handler table write enable |
| tbl_idx | input | 4 | Handler table write index |
| tbl_data | input | 16 | Handler address to write |
| core_pc | input | 16 | Core's current address, saved on preemption |
| done | input | 1 | One-cycle pulse: running handler finished |
| disp_ready | input | 1 | Core accepts the offered dispatch |
| disp_valid | output | 1 | A dispatch is offered |
| disp_addr | output | 16 | Handler start or resume address |
| disp_hi | output | 1 | Offered dispatch is urgent |
| disp_resume | output | 1 | Offered dispatch resumes a suspended handler |
| disp_preempt | output | 1 | Offered dispatch suspends the running normal handler |
| hi_ovf | output | 1 | Sticky urgent FIFO overflow |
| lo_ovf | output | 1 | Sticky normal FIFO overflow |
| sleep | output | 1 | System may sleep |

## Verification
With the block idle, a post sampled at one rising edge shows up as `disp_valid` at the next rising edge. The dispatch is accepted at the first edge where `disp_ready` is also 1. `sleep` rises one edge after the idle condition holds, and it falls in the same cycle as a post because it is gated directly by the strobes. Stimulus changes just after each rising edge. A monitor samples on the falling edge, takes any accepted dispatch there and compares it against the next item in a scoreboard queue that the driver filled from the requirements. Level checks are also made at falling edges: hold under back-pressure, no dispatch during an urgent handler, and the sleep and overflow flags.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LO   = 2'd1,
    ACT_HI   = 2'd2
  } act_e;
endpackage

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW:0]  wr_q, rd_q;
  logic         push_ok;

  assign empty   = (wr_q == rd_q);
  assign full    = (wr_q[PW] != rd_q[PW]) && (wr_q[PW-1:0] == rd_q[PW-1:0]);
  assign push_ok = push && !full;
  assign dout    = mem[rd_q[PW-1:0]];

  // storage has no reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q[PW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
      ovf  <= 1'b0;
    end else begin
      if (push_ok)        wr_q <= wr_q + 1'b1;
      if (pop && !empty)  rd_q <= rd_q + 1'b1;
      if (push && full)   ovf  <= 1'b1;
    end
  end
endmodule

// File: rtl/evt_table.sv
module evt_table #(
  parameter int IDX_W = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  localparam int N = 2 ** IDX_W;

  logic [DW-1:0] mem [N];
  logic [N-1:0]  written_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     written_q <= '0;
    else if (we) written_q[widx] <= 1'b1;
  end

  assign rdata = written_q[ridx] ? mem[ridx] : '0;
endmodule

// File: rtl/evt_dispatch.sv
module evt_dispatch
  import evt_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int QDEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_post,
  input  logic [ID_W-1:0]   hi_id,
  input  logic              lo_post,
  input  logic [ID_W-1:0]   lo_id,
  input  logic              tbl_we,
  input  logic [ID_W-1:0]   tbl_idx,
  input  logic [ADDR_W-1:0] tbl_data,
  input  logic [ADDR_W-1:0] core_pc,
  input  logic              done,
  input  logic              disp_ready,
  output logic              disp_valid,
  output logic [ADDR_W-1:0] disp_addr,
  output logic              disp_hi,
  output logic              disp_resume,
  output logic              disp_preempt,
  output logic              hi_ovf,
  output logic              lo_ovf,
  output logic              sleep
);
  logic              hi_empty, hi_full, lo_empty, lo_full;
  logic [ID_W-1:0]   hi_head, lo_head, rd_idx;
  logic [ADDR_W-1:0] rd_addr;
  act_e              act_q;
  logic              saved_vld_q;
  logic [ADDR_W-1:0] saved_q;
  logic              sleep_q;
  logic              accept, preempt_ok, go_hi, go_res, go_lo;

  always_comb begin
    accept     = disp_valid && disp_ready;
    preempt_ok = (act_q == ACT_LO) && !done;
    go_hi  = !disp_valid && !hi_empty && ((act_q == ACT_NONE) || preempt_ok);
    go_res = !disp_valid && (act_q == ACT_NONE) && hi_empty && saved_vld_q;
    go_lo  = !disp_valid && (act_q == ACT_NONE) && hi_empty && !saved_vld_q && !lo_empty;
    rd_idx = go_hi ? hi_head : lo_head;
  end

  evt_fifo #(.W(ID_W), .DEPTH(QDEPTH)) u_hi_q (
    .clk(clk), .rst(rst), .push(hi_post), .din(hi_id), .pop(go_hi),
    .dout(hi_head), .empty(hi_empty), .full(hi_full), .ovf(hi_ovf)
  );

  evt_fifo #(.W(ID_W), .DEPTH(QDEPTH)) u_lo_q (
    .clk(clk), .rst(rst), .push(lo_post), .din(lo_id), .pop(go_lo),
    .dout(lo_head), .empty(lo_empty), .full(lo_full), .ovf(lo_ovf)
  );

  evt_table #(.IDX_W(ID_W), .DW(ADDR_W)) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .widx(tbl_idx), .wdata(tbl_data),
    .ridx(rd_idx), .rdata(rd_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid   <= 1'b0;
      disp_addr    <= '0;
      disp_hi      <= 1'b0;
      disp_resume  <= 1'b0;
      disp_preempt <= 1'b0;
      act_q        <= ACT_NONE;
      saved_vld_q  <= 1'b0;
      saved_q      <= '0;
    end else if (accept) begin
      disp_valid <= 1'b0;
      act_q      <= disp_hi ? ACT_HI : ACT_LO;
    end else if (go_hi) begin
      disp_valid   <= 1'b1;
      disp_addr    <= rd_addr;
      disp_hi      <= 1'b1;
      disp_resume  <= 1'b0;
      disp_preempt <= preempt_ok;
      if (preempt_ok) begin
        saved_vld_q <= 1'b1;
        saved_q     <= core_pc;
        act_q       <= ACT_NONE;
      end
    end else if (go_res) begin
      disp_valid   <= 1'b1;
      disp_addr    <= saved_q;
      disp_hi      <= 1'b0;
      disp_resume  <= 1'b1;
      disp_preempt <= 1'b0;
      saved_vld_q  <= 1'b0;
    end else if (go_lo) begin
      disp_valid   <= 1'b1;
      disp_addr    <= rd_addr;
      disp_hi      <= 1'b0;
      disp_resume  <= 1'b0;
      disp_preempt <= 1'b0;
    end else if (done) begin
      act_q <= ACT_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sleep_q <= 1'b0;
    else     sleep_q <= hi_empty && lo_empty && (act_q == ACT_NONE) && !disp_valid
                        && !saved_vld_q && !hi_post && !lo_post;
  end

  assign sleep = sleep_q && !hi_post && !lo_post;
endmodule

// File: rtl/evt_dispatch_chk.sv
module evt_dispatch_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              hi_post,
  input logic              lo_post,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [ADDR_W-1:0] disp_addr,
  input logic              disp_hi,
  input logic              disp_resume,
  input logic              disp_preempt,
  input logic              hi_ovf,
  input logic              lo_ovf,
  input logic              sleep
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_addr) && $stable(disp_hi)
                                  && $stable(disp_resume) && $stable(disp_preempt));

  assert_hi_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    hi_ovf |=> hi_ovf);

  assert_lo_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    lo_ovf |=> lo_ovf);

  assert_preempt_urgent_R6: assert property (@(posedge clk) disable iff (rst)
    disp_valid && disp_preempt |-> disp_hi && !disp_resume);

  assert_resume_normal_R8: assert property (@(posedge clk) disable iff (rst)
    disp_valid && disp_resume |-> !disp_hi);

  assert_wake_on_post_R9: assert property (@(posedge clk) disable iff (rst)
    (hi_post || lo_post) |-> !sleep);

  assert_sleep_idle_R9: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !disp_valid);
endmodule

bind evt_dispatch evt_dispatch_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .hi_post(hi_post), .lo_post(lo_post),
  .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_addr(disp_addr),
  .disp_hi(disp_hi), .disp_resume(disp_resume), .disp_preempt(disp_preempt),
  .hi_ovf(hi_ovf), .lo_ovf(lo_ovf), .sleep(sleep)
);

// File: tb/evt_dispatch_tb_top.sv
module evt_dispatch_tb_top;
  localparam int CLK_P = 10;
  localparam int WDOG  = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hi_post = 1'b0, lo_post = 1'b0;
  logic [3:0]  hi_id = '0, lo_id = '0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [15:0] tbl_data = '0;
  logic [15:0] core_pc = '0;
  logic        done = 1'b0;
  logic        disp_ready = 1'b1;
  logic        disp_valid, disp_hi, disp_resume, disp_preempt, hi_ovf, lo_ovf, sleep;
  logic [15:0] disp_addr;

  always #(CLK_P/2) clk = ~clk;

  evt_dispatch dut_i (
    .clk(clk), .rst(rst), .hi_post(hi_post), .hi_id(hi_id), .lo_post(lo_post), .lo_id(lo_id),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data), .core_pc(core_pc), .done(done),
    .disp_ready(disp_ready), .disp_valid(disp_valid), .disp_addr(disp_addr), .disp_hi(disp_hi),
    .disp_resume(disp_resume), .disp_preempt(disp_preempt), .hi_ovf(hi_ovf), .lo_ovf(lo_ovf),
    .sleep(sleep)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic        hi;
    logic        res;
    logic        pre;
    logic [7:0]  req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0, n_acc = 0, acc_goal = 0;

  function automatic logic [15:0] tbl_val(int i);
    return (i == 15) ? 16'h0000 : 16'h1000 + 16'(i) * 16'h0111;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_item(logic [15:0] a, bit h, bit r, bit p, int req);
    exp_t e;
    e.addr = a; e.hi = h; e.res = r; e.pre = p; e.req = 8'(req);
    exp_q.push_back(e);
  endtask

  // monitor: scoreboard compare on accepted dispatches
  always @(negedge clk) begin
    if (!rst && disp_valid && disp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected dispatch", longint'(disp_addr), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(disp_addr == e.addr && disp_hi == e.hi && disp_resume == e.res &&
              disp_preempt == e.pre, $sformatf("R%0d dispatch {addr,hi,res,pre}", e.req),
              {disp_addr, disp_hi, disp_resume, disp_preempt},
              {e.addr, e.hi, e.res, e.pre});
      end
      n_acc++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic post(bit hp, logic [3:0] hid, bit lp, logic [3:0] lid);
    tick();
    hi_post = hp; hi_id = hid; lo_post = lp; lo_id = lid;
    tick();
    hi_post = 1'b0; lo_post = 1'b0;
  endtask

  task automatic wait_acc();
    acc_goal++;
    while (n_acc < acc_goal) @(negedge clk);
  endtask

  task automatic pulse_done();
    tick(); done = 1'b1;
    tick(); done = 1'b0;
  endtask

  task automatic run_one();
    wait_acc();
    pulse_done();
  endtask

  task automatic main_seq();
    repeat (3) tick();
    rst = 1'b0;
    repeat (3) tick();
    @(negedge clk);
    check(disp_valid == 0, "R4 reset valid", disp_valid, 0);
    check(hi_ovf == 0 && lo_ovf == 0, "R3 reset ovf", {hi_ovf, lo_ovf}, 0);
    check(sleep == 1, "R9 sleep after reset", sleep, 1);

    // program table, leave entry 15 unwritten (R2)
    for (int i = 0; i < 15; i++) begin
      tick(); tbl_we = 1'b1; tbl_idx = 4'(i); tbl_data = tbl_val(i);
    end
    tick(); tbl_we = 1'b0;

    // R2 basic lookup
    expect_item(tbl_val(3), 0, 0, 0, 2);
    post(0, 0, 1, 3); run_one();
    // R2 unwritten entry reads zero
    expect_item(16'h0000, 0, 0, 0, 2);
    post(0, 0, 1, 15); run_one();

    // R5 simultaneous posts, urgent first
    expect_item(tbl_val(1), 1, 0, 0, 5);
    expect_item(tbl_val(2), 0, 0, 0, 5);
    post(1, 1, 1, 2); run_one(); run_one();

    // R1 ordering within one priority
    expect_item(tbl_val(4), 0, 0, 0, 1);
    expect_item(tbl_val(5), 0, 0, 0, 1);
    expect_item(tbl_val(6), 0, 0, 0, 1);
    post(0, 0, 1, 4); post(0, 0, 1, 5); post(0, 0, 1, 6);
    run_one(); run_one(); run_one();

    // R4 hold under back-pressure
    disp_ready = 1'b0;
    expect_item(tbl_val(7), 1, 0, 0, 4);
    post(1, 7, 0, 0);
    repeat (2) tick();
    @(negedge clk);
    check(disp_valid == 1 && disp_addr == tbl_val(7), "R4 held offer", {disp_valid, disp_addr},
          {1'b1, tbl_val(7)});
    repeat (3) tick();
    @(negedge clk);
    check(disp_valid == 1 && disp_addr == tbl_val(7), "R4 still held", {disp_valid, disp_addr},
          {1'b1, tbl_val(7)});
    tick(); disp_ready = 1'b1;
    run_one();

    // R6 preemption, R7 no nesting, R8 resume
    core_pc = 16'hBEEF;
    expect_item(tbl_val(8), 0, 0, 0, 6);
    post(0, 0, 1, 8); wait_acc();
    expect_item(tbl_val(9), 1, 0, 1, 6);
    expect_item(tbl_val(11), 1, 0, 0, 7);
    expect_item(16'hBEEF, 0, 1, 0, 8);
    expect_item(tbl_val(10), 0, 0, 0, 8);
    post(1, 9, 1, 10); wait_acc();
    post(1, 11, 0, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(disp_valid == 0, "R7 no dispatch in urgent handler", disp_valid, 0);
    end
    pulse_done();
    run_one(); run_one(); run_one();

    // R3 overflow: ids 0..9 with back-pressure, id 9 dropped
    disp_ready = 1'b0;
    for (int i = 0; i < 9; i++) begin
      expect_item(tbl_val(i), 1, 0, 0, 3);
      post(1, 4'(i), 0, 0);
    end
    @(negedge clk);
    check(hi_ovf == 0, "R3 no overflow at exactly full", hi_ovf, 0);
    post(1, 9, 0, 0);
    @(negedge clk);
    check(hi_ovf == 1, "R3 overflow set", hi_ovf, 1);
    check(lo_ovf == 0, "R3 other port unaffected", lo_ovf, 0);
    tick(); disp_ready = 1'b1;
    for (int i = 0; i < 9; i++) run_one();
    repeat (3) tick();
    @(negedge clk);
    check(disp_valid == 0, "R3 dropped event never dispatched", disp_valid, 0);
    check(hi_ovf == 1, "R3 overflow sticky", hi_ovf, 1);

    // R9 sleep and wake
    check(sleep == 1, "R9 sleep when idle", sleep, 1);
    tick(); lo_post = 1'b1; lo_id = 4'd0;
    @(negedge clk);
    check(sleep == 0, "R9 wake in post cycle", sleep, 0);
    expect_item(tbl_val(0), 0, 0, 0, 9);
    tick(); lo_post = 1'b0;
    @(negedge clk);
    check(sleep == 0, "R9 awake while busy", sleep, 0);
    run_one();
    repeat (2) tick();
    @(negedge clk);
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (WDOG) @(posedge clk);
        check(1'b0, "R1 watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule